// File: doc/BRIEF.md
# Overcurrent Breaker and Interrupt Controller

This block holds two digital circuit breakers, one for a left and one for a right power channel, and the interrupt register that reports their trips to a host. Each channel has a requested instrument power bit. When an overcurrent input rises while power is requested, the breaker for that channel trips. It forces that channel's power output off and stays latched until the host drops the power request for the channel.

The interrupt register holds three read/write enables: one per channel and one global. It also holds three read-only flags. A channel flag is high while its breaker is tripped and both its own enable and the global enable are set. The global flag and the interrupt output to the host follow the OR of the channel flags. A trip is the only thing that can raise an interrupt. Reading the register never clears a flag: only switching the breaker off does.

The overcurrent inputs are asynchronous comparator outputs. Each passes through a flip-flop synchronizer, and only its rising edge can set the trip latch.

Top module: `ocp_irq_ctrl`

## Requirements
- R1: After reset all enables are 0, both trip latches are 0, `irq` is 0 and `reg_rdata` is 0.
- R2: A write (`reg_wr`=1) loads the left channel enable from `reg_wdata[5]`, the right channel enable from `reg_wdata[4]` and the global enable from `reg_wdata[3]` at the next clock edge. A read (`reg_rd`=1) captures the register image into `reg_rdata` at the next edge, with the enables in bits 5:3.
- R3: Write data in bits 2:0 has no effect on any flag, enable or output.
- R4: A rising edge on `oc_in[c]` while `pwr_req[c]`=1 sets `trip[c]` at the third clock edge after the input change: two synchronizer stages plus the latch.
- R5: While `trip[c]`=1, `pwr_out[c]` is 0. The latch stays set after `oc_in[c]` falls, for as long as the power request stays high. When not tripped, `pwr_out[c]` equals `pwr_req[c]`.
- R6: An overcurrent edge while `pwr_req[c]`=0 does not trip. A level that is already high when power is turned on does not trip either.
- R7: `trip[c]` clears at the first clock edge at which `pwr_req[c]` is 0.
- R8: The register image has the left flag in bit 2 and the right flag in bit 1. Each is 1 exactly when its trip latch, its channel enable and the global enable are all 1.
- R9: Bit 0 (global flag) and `irq` are 1 exactly when at least one channel flag is 1.
- R10: Reads do not change any enable, flag, trip latch or `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Interrupt register write strobe |
| reg_wdata | input | 6 | Write data (bits 5:3 used) |
| reg_rd | input | 1 | Read strobe; captures the register image |
| reg_rdata | output | 6 | Captured register image |
| pwr_req | input | 2 | Requested instrument power, bit 0 left, bit 1 right |
| oc_in | input | 2 | Asynchronous overcurrent inputs, bit 0 left, bit 1 right |
| pwr_out | output | 2 | Effective instrument power after the breakers |
| trip | output | 2 | Latched breaker trip state |
| irq | output | 1 | Interrupt to the host |

## Verification
A change on an overcurrent input reaches the trip latch at the third clock edge, so the bench checks that `trip` is still low after the second edge and high after the third. Enables land one edge after the write strobe. A captured read appears one edge after the read strobe. A dropped power request clears the latch on the next edge. `irq` and `pwr_out` are combinational from the registered state. All inputs change on the falling clock edge, and every output is sampled on a falling edge after the exact count of rising edges.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    localparam int CH_N   = 2;
    localparam int REG_W  = 6;
    localparam int EN_LSB = 3;

    typedef struct packed {
        logic [CH_N-1:0] ch_en;   // index 0 left, 1 right
        logic            glb_en;
    } irq_en_t;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], async_i};
        s_d.prev = s_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sh[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/ocp_breaker.sv
module ocp_breaker (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    input  logic oc_rise,
    output logic trip,
    output logic pwr_out
);
    logic trip_d, trip_q;

    always_comb begin
        trip_d = trip_q;
        if (!pwr_req)     trip_d = 1'b0;
        else if (oc_rise) trip_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trip_q <= 1'b0;
        else        trip_q <= trip_d;
    end

    assign trip    = trip_q;
    assign pwr_out = pwr_req & ~trip_q;

    // R7: power request low clears the latch next edge
    a_r7_clear_on_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_req |=> !trip_q);
    // R5: a tripped channel never drives power
    a_r5_power_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
        trip_q |-> !pwr_out);
    // R5: latch holds while power stays requested
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        trip_q && pwr_req |=> trip_q);
    // R6: a trip only follows a cycle with power requested
    a_r6_trip_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_q) |-> $past(pwr_req));
endmodule

// File: rtl/ocp_irq_ctrl.sv
module ocp_irq_ctrl
    import ocp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_rd,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [CH_N-1:0]  pwr_req,
    input  logic [CH_N-1:0]  oc_in,
    output logic [CH_N-1:0]  pwr_out,
    output logic [CH_N-1:0]  trip,
    output logic             irq
);
    typedef struct packed {
        irq_en_t          en;
        logic [REG_W-1:0] rdata;
    } ctrl_t;

    ctrl_t            c_d, c_q;
    logic [CH_N-1:0]  oc_rise;
    logic [CH_N-1:0]  ch_flag;
    logic             glb_flag;
    logic [REG_W-1:0] image;

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        ocp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .async_i(oc_in[c]), .rise_o(oc_rise[c])
        );
        ocp_breaker u_brk (
            .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req[c]), .oc_rise(oc_rise[c]),
            .trip(trip[c]), .pwr_out(pwr_out[c])
        );
        assign ch_flag[c] = trip[c] & c_q.en.ch_en[c] & c_q.en.glb_en;
        // left channel enable in bit 5 / flag in bit 2; right in 4 / 1
        assign image[REG_W-1-c]      = c_q.en.ch_en[c];
        assign image[EN_LSB-1-c]     = ch_flag[c];
    end

    assign glb_flag      = |ch_flag;
    assign image[EN_LSB] = c_q.en.glb_en;
    assign image[0]      = glb_flag;

    always_comb begin
        c_d = c_q;
        if (reg_wr) begin
            for (int c = 0; c < CH_N; c++) c_d.en.ch_en[c] = reg_wdata[REG_W-1-c];
            c_d.en.glb_en = reg_wdata[EN_LSB];
        end
        if (reg_rd) c_d.rdata = image;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign reg_rdata = c_q.rdata;
    assign irq       = glb_flag;

    // R2: write lands on the enables at the next edge
    a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> c_q.en.glb_en == $past(reg_wdata[EN_LSB]));
    // R10: without a write the enables never move, reads included
    a_r10_enables_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(c_q.en));
    // R8: an interrupt needs global enable and a tripped breaker
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (c_q.en.glb_en && (|trip)));
    // R9: with every latch clear there is no interrupt
    a_r9_no_trip_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (trip == '0) |-> !irq);
endmodule

// File: tb/test_ocp_irq_ctrl.sv
module test_ocp_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr, reg_rd;
    logic [5:0] reg_wdata, reg_rdata;
    logic [1:0] pwr_req, oc_in, pwr_out, trip;
    logic       irq;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    ocp_irq_ctrl i_ocp_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pwr_req(pwr_req),
        .oc_in(oc_in), .pwr_out(pwr_out), .trip(trip), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step(1);
        reg_wr = 1'b0; reg_wdata = 6'h00;
    endtask

    task automatic rd();
        reg_rd = 1'b1;
        step(1);
        reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_wdata = 0; pwr_req = 0; oc_in = 0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        rd();
        chk("R1 rdata", reg_rdata, 6'h00);
        chk("R1 trip", trip, 2'b00);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_enables();
        do_reset();
        wr(6'h3F);
        rd();
        chk("R2 all enables", reg_rdata, 6'h38);
        chk("R3 low bits ignored", irq, 0);
        wr(6'h27);
        rd();
        chk("R3 left+low bits", reg_rdata, 6'h20);
        wr(6'h10);
        rd();
        chk("R2 right only", reg_rdata, 6'h10);
    endtask

    task automatic t_trip();
        do_reset();
        pwr_req = 2'b01;
        step(1);
        chk("R5 power passes", pwr_out, 2'b01);
        oc_in[0] = 1'b1;
        step(2);
        chk("R4 not yet at edge 2", trip, 2'b00);
        step(1);
        chk("R4 trip at edge 3", trip, 2'b01);
        chk("R5 power forced off", pwr_out, 2'b00);
        oc_in[0] = 1'b0;
        step(4);
        chk("R5 latch held", trip, 2'b01);
        pwr_req = 2'b00;
        step(1);
        chk("R7 cleared", trip, 2'b00);
    endtask

    task automatic t_no_trip();
        do_reset();
        oc_in = 2'b10;
        step(5);
        chk("R6 unpowered edge", trip, 2'b00);
        pwr_req = 2'b10;
        step(5);
        chk("R6 held level at power on", trip, 2'b00);
        chk("R6 power passes", pwr_out, 2'b10);
        oc_in = 2'b00;
        step(3);
        oc_in = 2'b10;
        step(3);
        chk("R4 right channel trip", trip, 2'b10);
    endtask

    task automatic t_flags();
        do_reset();
        pwr_req = 2'b11;
        step(1);
        oc_in = 2'b10;
        step(3);
        chk("R8 tripped but disabled irq", irq, 0);
        wr(6'h18);
        rd();
        chk("R8 right flag", reg_rdata, 6'h1B);
        chk("R9 irq", irq, 1);
        rd();
        rd();
        chk("R10 reread same", reg_rdata, 6'h1B);
        chk("R10 trip kept", trip, 2'b10);
        wr(6'h28);
        rd();
        chk("R8 other channel enabled", reg_rdata, 6'h28);
        chk("R9 irq low", irq, 0);
        wr(6'h30);
        rd();
        chk("R8 global off", reg_rdata, 6'h30);
        wr(6'h38);
        oc_in = 2'b11;
        step(3);
        rd();
        chk("R9 both flags", reg_rdata, 6'h3F);
        pwr_req = 2'b01;
        step(1);
        rd();
        chk("R7 right flag gone", reg_rdata, 6'h3D);
        chk("R9 irq still", irq, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_enables();
        t_trip();
        t_no_trip();
        t_flags();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule